// File: doc/BRIEF.md
# RGB to YUV Batch Converter

This block is a register-mapped accelerator that turns a batch of colour pixels from RGB into YUV. Software fills a bank of input words with one RGB pixel each, writes a start bit, and then either waits for the interrupt line or polls a status word. The block converts one pixel per clock using fixed-point coefficients scaled by 1024. It stores the results in a bank of output words and raises a level interrupt once the last result is stored. Software reads the results back and acknowledges through a separate control word, which drops the interrupt and the done flag.

The sequencing is a four-state machine. IDLE waits for a start. RUN feeds one stored pixel per clock into the conversion stage. FLUSH lets the last pixel leave the one-stage multiply-accumulate pipeline. DONE holds the interrupt. The transitions are: IDLE to RUN on a start write; RUN to FLUSH when the final pixel index is issued; FLUSH to DONE on the next clock; DONE to IDLE on an acknowledge; and DONE to RUN on a fresh start. The bus is word addressed by byte offset. Every read or write request gets a registered one-cycle ready pulse, and read data is valid with it.

Top module: `rgb2yuv_batch`

## Requirements
- R1: After reset the status word reads 0, the interrupt is low and every output word reads 0.
- R2: Output bits [23:16] hold Y = (306R + 601G + 117B) >> 10, clamped to 0..255, where input bits [23:16]=R, [15:8]=G, [7:0]=B are unsigned.
- R3: Output bits [15:8] hold U = (-173R - 339G + 512B) >>> 10 and bits [7:0] hold V = (512R - 429G - 83B) >>> 10. Both are signed two's complement from a floor (arithmetic) shift, clamped to -128..127.
- R4: The interrupt rises only after all eight results are stored. It is seen high after the ninth rising edge following the edge that accepts the start write.
- R5: The status word is at offset 0x64. Writing 1 to bit 0 starts a batch when not busy. Bit 0 reads 1 while busy and bit 1 reads 1 once the batch is done.
- R6: Writing 1 to bit 0 of the word at 0x68 clears both the interrupt and the done bit. Bit 0 of that word reads back the interrupt.
- R7: Writes to the input words while a batch is running are ignored; the stored pixel is unchanged.
- R8: A start write while a batch is running is ignored, and the running batch ends at its original time.
- R9: Each read or write request is answered by bus_ready high for exactly one cycle on the next edge, with read data valid then. Offsets that map to nothing read as 0.
- R10: Input words at offsets 0x00 to 0x1C read back what was written; output words sit at 0xC8 to 0xE4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | One-cycle acknowledge of a request |
| irq | output | 1 | Level interrupt, high while a finished batch is unacknowledged |

## Verification
The bench builds the block with its defaults: eight pixels per batch, a 10-bit coefficient fraction and an 8-bit offset bus. With these values the whole map of input words, status, interrupt control and output words is exercised, along with the exact nine-edge latency from start to interrupt. The colour corners (black, white and the saturated primaries) drive U and V to their most negative and most positive reachable codes. A mid-batch disturbance issues a second start and an input write while the pipeline is full, to show that neither the timing nor the stored pixels move.

// File: rtl/yuv_pkg.sv
package yuv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FLUSH,
        ST_DONE
    } cvt_state_e;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_pix_t;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] u;
        logic [7:0] v;
    } yuv_pix_t;

    localparam logic [7:0] OFS_STATUS   = 8'h64;
    localparam logic [7:0] OFS_IRQCTL   = 8'h68;
    localparam logic [7:0] OFS_OUT_BASE = 8'hC8;

endpackage

// File: rtl/yuv_core.sv
module yuv_core
    import yuv_pkg::*;
#(
    parameter int FRAC  = 10,
    parameter int ACC_W = 20,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  rgb_pix_t         in_pix,
    input  logic [IDX_W-1:0] in_idx,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_idx,
    output yuv_pix_t         out_pix
);

    logic [2:0][7:0] chan;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_idx <= in_idx;
        end
    end

    // channel 0 = Y (unsigned clamp), 1 = U, 2 = V (signed clamp)
    for (genvar c = 0; c < 3; c++) begin : g_ch
        localparam int KR = (c == 0) ? 306 : ((c == 1) ? -173 : 512);
        localparam int KG = (c == 0) ? 601 : ((c == 1) ? -339 : -429);
        localparam int KB = (c == 0) ? 117 : ((c == 1) ? 512 : -83);
        localparam int HI = (c == 0) ? 255 : 127;
        localparam int LO = (c == 0) ? 0 : -128;

        logic signed [ACC_W-1:0] acc_q;
        int                      sum;
        int                      sh;

        always_comb begin
            sum = KR * int'(in_pix.r) + KG * int'(in_pix.g) + KB * int'(in_pix.b);
        end

        always_ff @(posedge clk) begin
            if (!rst_n)        acc_q <= '0;
            else if (in_valid) acc_q <= ACC_W'(sum);
        end

        always_comb begin
            sh = int'(acc_q) >>> FRAC;
            if (sh > HI)      sh = HI;
            else if (sh < LO) sh = LO;
            chan[c] = 8'(sh);
        end
    end

    assign out_pix = '{y: chan[0], u: chan[1], v: chan[2]};

endmodule

// File: rtl/yuv_ctrl.sv
module yuv_ctrl
    import yuv_pkg::*;
#(
    parameter int NPIX  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             ack_req,
    output logic             busy,
    output logic             done,
    output logic             irq,
    output logic             issue_valid,
    output logic [IDX_W-1:0] issue_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPIX - 1);

    cvt_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_req) state_d = ST_RUN;
            ST_RUN:   if (idx_q == LAST_IDX) state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_DONE;
            ST_DONE: begin
                if (start_req)    state_d = ST_RUN;
                else if (ack_req) state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                idx_q <= '0;
        else if (state_q == ST_RUN) idx_q <= idx_q + 1'b1;
        else                        idx_q <= '0;
    end

    always_comb begin
        busy        = (state_q == ST_RUN) || (state_q == ST_FLUSH);
        done        = (state_q == ST_DONE);
        irq         = (state_q == ST_DONE);
        issue_valid = (state_q == ST_RUN);
        issue_idx   = idx_q;
    end

    // R4
    done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && $past(state_q) != ST_DONE) |-> $past(state_q) == ST_FLUSH);

    // R5
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && state_q == ST_IDLE) |=> state_q == ST_RUN);

endmodule

// File: rtl/rgb2yuv_batch.sv
module rgb2yuv_batch
    import yuv_pkg::*;
#(
    parameter int NPIX   = 8,
    parameter int FRAC   = 10,
    parameter int ACC_W  = 20,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              irq
);

    localparam int IDX_W  = (NPIX > 1) ? $clog2(NPIX) : 1;
    localparam int CNT_W  = IDX_W + 1;
    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [WIDX_W-1:0] W_STATUS = WIDX_W'(OFS_STATUS >> 2);
    localparam logic [WIDX_W-1:0] W_IRQCTL = WIDX_W'(OFS_IRQCTL >> 2);
    localparam logic [WIDX_W-1:0] W_OUT0   = WIDX_W'(OFS_OUT_BASE >> 2);
    localparam logic [WIDX_W-1:0] W_NPIX   = WIDX_W'(NPIX);

    logic [NPIX-1:0][23:0] in_buf;
    logic [NPIX-1:0][23:0] out_buf;
    logic [WIDX_W-1:0]     widx, out_off;
    logic                  in_hit, out_hit;
    logic                  start_req, ack_req, start_go;
    logic                  busy, done;
    logic                  iss_valid, res_valid;
    logic [IDX_W-1:0]      iss_idx, res_idx;
    yuv_pix_t              res_pix;
    logic [CNT_W-1:0]      wr_cnt;
    logic [31:0]           rd_mux;
    logic                  unused_bits;

    assign unused_bits = ^{1'b0, bus_addr[1:0], bus_wdata[31:24]};

    assign widx      = bus_addr[ADDR_W-1:2];
    assign out_off   = widx - W_OUT0;
    assign in_hit    = widx < W_NPIX;
    assign out_hit   = (widx >= W_OUT0) && (out_off < W_NPIX);
    assign start_req = bus_wr && (widx == W_STATUS) && bus_wdata[0];
    assign ack_req   = bus_wr && (widx == W_IRQCTL) && bus_wdata[0];
    assign start_go  = start_req && !busy;

    yuv_ctrl #(.NPIX(NPIX), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .ack_req    (ack_req),
        .busy       (busy),
        .done       (done),
        .irq        (irq),
        .issue_valid(iss_valid),
        .issue_idx  (iss_idx)
    );

    yuv_core #(.FRAC(FRAC), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (iss_valid),
        .in_pix   (rgb_pix_t'(in_buf[iss_idx])),
        .in_idx   (iss_idx),
        .out_valid(res_valid),
        .out_idx  (res_idx),
        .out_pix  (res_pix)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_buf  <= '0;
            out_buf <= '0;
            wr_cnt  <= '0;
        end else begin
            if (bus_wr && in_hit && !busy) in_buf[widx[IDX_W-1:0]] <= bus_wdata[23:0];
            if (res_valid) out_buf[res_idx] <= res_pix;
            if (start_go)       wr_cnt <= '0;
            else if (res_valid) wr_cnt <= wr_cnt + 1'b1;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (in_hit)                rd_mux = {8'h00, in_buf[widx[IDX_W-1:0]]};
        else if (out_hit)          rd_mux = {8'h00, out_buf[out_off[IDX_W-1:0]]};
        else if (widx == W_STATUS) rd_mux = {30'd0, done, busy};
        else if (widx == W_IRQCTL) rd_mux = {31'd0, irq};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_rd || bus_wr;
            if (bus_rd) bus_rdata <= rd_mux;
        end
    end

    // R4
    irq_full_batch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wr_cnt == CNT_W'(NPIX));

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !start_req) |=> (!irq && !done));

    // R7
    locked_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && in_hit) |=> $stable(in_buf));

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |=> bus_ready);

endmodule

// File: tb/sim_rgb2yuv_batch.sv
module sim_rgb2yuv_batch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    rgb2yuv_batch u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .bus_ready(bus_ready),
        .irq      (irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic rdy);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata; rdy = bus_ready;
        bus_rd = 1'b0;
    endtask

    function automatic int clampi(input int x, input int lo, input int hi);
        return (x < lo) ? lo : ((x > hi) ? hi : x);
    endfunction

    function automatic logic [23:0] ref_yuv(input logic [23:0] p);
        int r, g, b, y, u, v;
        r = int'(p[23:16]); g = int'(p[15:8]); b = int'(p[7:0]);
        y = clampi((306 * r + 601 * g + 117 * b) >>> 10, 0, 255);
        u = clampi((-173 * r - 339 * g + 512 * b) >>> 10, -128, 127);
        v = clampi((512 * r - 429 * g - 83 * b) >>> 10, -128, 127);
        return {8'(y), 8'(u), 8'(v)};
    endfunction

    task automatic t_reset();
        logic [31:0] d; logic rdy;
        bus_read(8'h64, d, rdy);
        check(d == 0, "R1 status after reset", d, 0);
        check(irq == 1'b0, "R1 irq after reset", {31'd0, irq}, 0);
        bus_read(8'hC8, d, rdy);
        check(d == 0, "R1 output word after reset", d, 0);
    endtask

    task automatic t_batch(input logic [7:0][23:0] pix, input bit disturb, input string name);
        logic [31:0] d; logic rdy; int n;
        for (int i = 0; i < 8; i++) bus_write(8'(4 * i), {8'h00, pix[i]});
        bus_read(8'h0C, d, rdy);
        check(d[23:0] == pix[3], {"R10 input readback ", name}, d, {8'h00, pix[3]});
        bus_write(8'h64, 32'h1);
        n = 0;
        while (!irq && n < 40) begin
            if (disturb) begin
                if (n == 1) begin bus_wr = 1'b1; bus_addr = 8'h64; bus_wdata = 32'h1; end
                if (n == 2) begin bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h00ABCDEF; end
                if (n == 3) bus_wr = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        bus_wr = 1'b0;
        if (disturb) check(n == 9, "R8 restart ignored, batch length", n, 9);
        else         check(n == 9, {"R4 irq latency ", name}, n, 9);
        bus_read(8'h64, d, rdy);
        check(d == 32'h2, {"R5 status done ", name}, d, 32'h2);
        bus_read(8'h68, d, rdy);
        check(d == 32'h1, {"R6 irq readback ", name}, d, 32'h1);
        for (int i = 0; i < 8; i++) begin
            logic [23:0] e;
            e = ref_yuv(pix[i]);
            bus_read(8'(8'hC8 + 4 * i), d, rdy);
            check(d[23:16] == e[23:16], {"R2 Y ", name}, d, {8'h00, e});
            check(d[15:0] == e[15:0], {"R3 U/V ", name}, d, {8'h00, e});
        end
        if (disturb) begin
            bus_read(8'h00, d, rdy);
            check(d[23:0] == pix[0], "R7 input write while busy ignored", d, {8'h00, pix[0]});
        end
        bus_write(8'h68, 32'h1);
        @(negedge clk);
        check(irq == 1'b0, {"R6 irq cleared ", name}, {31'd0, irq}, 0);
        bus_read(8'h64, d, rdy);
        check(d == 0, {"R6 done cleared ", name}, d, 0);
    endtask

    task automatic t_busy_status();
        logic [31:0] d; logic rdy;
        bus_write(8'h64, 32'h1);
        bus_read(8'h64, d, rdy);
        check(d == 32'h1, "R5 busy bit while running", d, 32'h1);
        check(irq == 1'b0, "R4 irq low mid batch", {31'd0, irq}, 0);
        while (!irq) @(negedge clk);
        bus_write(8'h68, 32'h1);
    endtask

    task automatic t_bus();
        logic [31:0] d; logic rdy;
        bus_read(8'h40, d, rdy);
        check(d == 0, "R9 unmapped read", d, 0);
        check(rdy == 1'b1, "R9 ready with read", {31'd0, rdy}, 1);
        @(negedge clk);
        check(bus_ready == 1'b0, "R9 ready single cycle", {31'd0, bus_ready}, 0);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0][23:0] set_a;
        logic [7:0][23:0] set_b;
        set_a[0] = 24'hFFFFFF; set_a[1] = 24'h000000; set_a[2] = 24'hFF0000; set_a[3] = 24'h00FF00;
        set_a[4] = 24'h0000FF; set_a[5] = 24'h808080; set_a[6] = 24'hFFFF00; set_a[7] = 24'h00FFFF;
        for (int i = 0; i < 8; i++) set_b[i] = 24'((i * 24'h3B1F7) ^ (i * 24'h0C55A9) ^ 24'h5A3C96);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_batch(set_a, 1'b0, "corners");
        t_batch(set_b, 1'b0, "mixed");
        t_batch(set_a, 1'b1, "disturbed");
        t_busy_status();
        t_bus();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule